// File: doc/BRIEF.md
# Divided-Clock Trigger Aligner

This block lets several devices that run from the same sample-clock frequency react to a shared trigger on the same sample. It divides the sample clock by a programmable even ratio to form a slower synchronization clock. The clock is represented inside the sample-clock domain by a pair of single-cycle phase strobes, one for the rising phase and one for the falling phase. A trigger that the device sends is held until the next rising phase. A trigger that the device receives is synchronized, edge-detected and held pending until the next falling phase. The block then hands it to the consumer as a one-sample pulse.

Because sending and receiving use opposite halves of the slow clock, a propagation skew of less than half a synchronization period cannot make two devices act on different cycles. The cost is a trigger-to-response delay that varies by up to one synchronization period. A larger ratio gives a larger variation. A bypass input drops the alignment, so that triggers act on the next sample clock. A synchronization-restart input is shared by all devices. It restarts the divider, so that every device starts its rising phase on the same sample.

Top module: `trig_align`

## Requirements
- R1: While `rstN` is low, `trigOut` and `trigRecv` are 0 and `syncClk` is 1. The divider restarts at phase 0.
- R2: The effective ratio R is even. Counting sample cycles from a restart as phase p = 0, 1, 2, and so on, `syncClk` is 1 when (p mod R) < R/2 and 0 otherwise.
- R3: In aligned mode (`bypassEn` = 0), a one-cycle `sendReq` in phase p0 produces exactly one single-cycle `trigOut` pulse. The pulse occurs in phase r+1, where r is the first multiple of R strictly greater than p0.
- R4: In aligned mode, a rising edge of `trigIn` that is set up before the clock edge ending phase q0 produces exactly one single-cycle `trigRecv` pulse. The pulse occurs in phase f+1, where f is the smallest phase ≥ q0+3 with (f mod R) = R/2.
- R5: In bypass mode, `trigOut` is 1 in the cycle after each cycle in which `sendReq` is 1.
- R6: In bypass mode, a rising edge of `trigIn` that is set up before the clock edge ending phase q0 gives a single-cycle `trigRecv` pulse in phase q0+3.
- R7: A second `sendReq` that arrives while an earlier request is still pending merges into it, and only one `trigOut` pulse results.
- R8: A one-cycle assertion of `syncRst` makes the next cycle phase 0, whatever the previous divider phase was.
- R9: An odd `divRatio` is rounded down to the next even value. A `divRatio` below 2 acts as 2.
- R10: Holding `trigIn` high for many cycles yields only one `trigRecv` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncRst | input | 1 | Divider restart, shared by all devices |
| divRatio | input | DIV_W | Requested divide ratio |
| bypassEn | input | 1 | 1 = act on next sample clock, 0 = align to sync clock |
| sendReq | input | 1 | Request to emit a trigger (sample domain) |
| trigIn | input | 1 | Incoming trigger, asynchronous |
| syncClk | output | 1 | Divided synchronization clock |
| trigOut | output | 1 | Aligned outgoing trigger pulse |
| trigRecv | output | 1 | Aligned received trigger pulse to the consumer |

## Verification
The assertions check the following on every cycle:
- The two phase strobes are never active together.
- A restart is followed at once by a rising phase.
- An aligned `trigOut` is always preceded by a rising strobe.
- An aligned `trigRecv` is always preceded by a falling strobe.
- `trigRecv` never lasts longer than one cycle.

Only the bench scenarios can show the following:
- The exact latencies in R3, R4 and R6 for several ratios and arrival offsets.
- The merging of requests.
- The rounding of odd and tiny ratios.
- That a held input yields a single event.

// File: rtl/trig_align_pkg.sv
package trig_align_pkg;

  // Phase strobes that the divider hands to the trigger datapath.
  typedef struct packed {
    logic riseTick;
    logic fallTick;
  } syncStrobes_t;

endpackage

// File: rtl/trig_align_divider.sv
module trig_align_divider
  import trig_align_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncRst,
  input  logic [DIV_W-1:0] divRatio,
  output syncStrobes_t     strobes,
  output logic             syncClk
);

  localparam logic [DIV_W-1:0] MIN_RATIO = DIV_W'(2);

  logic [DIV_W-1:0] effRatio;
  logic [DIV_W-1:0] halfRatio;
  logic [DIV_W-1:0] phaseCnt;
  logic             lastPhase;

  // R9: force an even ratio of at least two
  always_comb begin
    if (divRatio < MIN_RATIO) effRatio = MIN_RATIO;
    else                      effRatio = {divRatio[DIV_W-1:1], 1'b0};
    halfRatio = effRatio >> 1;
    lastPhase = (phaseCnt >= effRatio - DIV_W'(1));
  end

  // R8: restart puts the counter at phase 0
  always_ff @(posedge clk) begin
    if (!rstN)          phaseCnt <= '0;
    else if (syncRst)   phaseCnt <= '0;
    else if (lastPhase) phaseCnt <= '0;
    else                phaseCnt <= phaseCnt + DIV_W'(1);
  end

  always_comb begin
    strobes.riseTick = !syncRst && (phaseCnt == '0);
    strobes.fallTick = !syncRst && (phaseCnt == halfRatio);
    syncClk          = (phaseCnt < halfRatio);
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.riseTick && strobes.fallTick)); // R2

  AST_RESTART_RISES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(syncRst) && !syncRst) |-> strobes.riseTick); // R8

endmodule

// File: rtl/trig_align_datapath.sv
module trig_align_datapath
  import trig_align_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bypassEn,
  input  syncStrobes_t strobes,
  input  logic         sendReq,
  input  logic         trigIn,
  output logic         trigOut,
  output logic         trigRecv
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLevel;
  logic                   inEdge;
  logic                   inPend;
  logic                   outPend;
  logic                   outFire;
  logic                   inFire;

  // Input synchronizer chain
  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], trigIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncChain[SYNC_STAGES-1];
  end

  always_comb begin
    inEdge  = syncChain[SYNC_STAGES-1] && !prevLevel;   // R10
    outFire = outPend && strobes.riseTick;              // R3
    inFire  = inPend && strobes.fallTick;               // R4
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPend  <= 1'b0;
      inPend   <= 1'b0;
      trigOut  <= 1'b0;
      trigRecv <= 1'b0;
    end else if (bypassEn) begin
      outPend  <= 1'b0;
      inPend   <= 1'b0;
      trigOut  <= sendReq;                              // R5
      trigRecv <= inEdge;                               // R6
    end else begin
      outPend  <= sendReq || (outPend && !strobes.riseTick); // R7
      inPend   <= inEdge  || (inPend  && !strobes.fallTick);
      trigOut  <= outFire;
      trigRecv <= inFire;
    end
  end

  AST_OUT_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && !$past(bypassEn)) |-> $past(strobes.riseTick)); // R3

  AST_RECV_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (trigRecv && !$past(bypassEn)) |-> $past(strobes.fallTick)); // R4

  AST_RECV_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    trigRecv |=> !trigRecv); // R10

endmodule

// File: rtl/trig_align.sv
module trig_align
  import trig_align_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncRst,
  input  logic [DIV_W-1:0] divRatio,
  input  logic             bypassEn,
  input  logic             sendReq,
  input  logic             trigIn,
  output logic             syncClk,
  output logic             trigOut,
  output logic             trigRecv
);

  syncStrobes_t strobes;

  trig_align_divider #(.DIV_W(DIV_W)) u_divider (
    .clk      (clk),
    .rstN     (rstN),
    .syncRst  (syncRst),
    .divRatio (divRatio),
    .strobes  (strobes),
    .syncClk  (syncClk)
  );

  trig_align_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .bypassEn (bypassEn),
    .strobes  (strobes),
    .sendReq  (sendReq),
    .trigIn   (trigIn),
    .trigOut  (trigOut),
    .trigRecv (trigRecv)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!trigOut && !trigRecv) || !rstN); // R1

endmodule

// File: tb/test_trig_align.sv
`timescale 1ns/1ps
module test_trig_align;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncRst = 1'b0;
  logic [7:0] divRatio = 8'd4;
  logic       bypassEn = 1'b0;
  logic       sendReq = 1'b0;
  logic       trigIn = 1'b0;
  logic       syncClk, trigOut, trigRecv;

  int nVec = 0;
  int nBad = 0;
  int phase = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trig_align i_trig_align (
    .clk(clk), .rstN(rstN), .syncRst(syncRst), .divRatio(divRatio),
    .bypassEn(bypassEn), .sendReq(sendReq), .trigIn(trigIn),
    .syncClk(syncClk), .trigOut(trigOut), .trigRecv(trigRecv)
  );

  // Phase counter from the requirements: restart makes the next cycle phase 0.
  always @(posedge clk) begin
    if (syncRst) phase <= 0;
    else         phase <= phase + 1;
  end

  typedef struct packed {
    logic [7:0] ratio;
    logic       byp;
    logic       dirIn;
    logic [7:0] off;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd4,  1'b0, 1'b0, 8'd0},
    '{8'd4,  1'b0, 1'b0, 8'd3},
    '{8'd4,  1'b0, 1'b0, 8'd4},
    '{8'd8,  1'b0, 1'b0, 8'd2},
    '{8'd2,  1'b1, 1'b0, 8'd5},
    '{8'd4,  1'b0, 1'b1, 8'd0},
    '{8'd4,  1'b0, 1'b1, 8'd3},
    '{8'd8,  1'b0, 1'b1, 8'd1},
    '{8'd8,  1'b1, 1'b1, 8'd2},
    '{8'd16, 1'b0, 1'b1, 8'd5},
    '{8'd16, 1'b0, 1'b0, 8'd16},
    '{8'd2,  1'b0, 1'b1, 8'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expOut(int r, bit byp, int p0);
    if (byp) return p0 + 1;
    return (p0 / r + 1) * r + 1;
  endfunction

  function automatic int expIn(int r, bit byp, int q0);
    int p;
    if (byp) return q0 + 3;
    p = q0 + 3;
    while ((p % r) != r / 2) p++;
    return p + 1;
  endfunction

  task automatic restart();
    @(negedge clk) syncRst = 1'b1;
    @(negedge clk) syncRst = 1'b0;
  endtask

  task automatic findPulse(input bit pickIn, input int limit,
                           output int firstPh, output int count);
    firstPh = -1;
    count = 0;
    for (int i = 0; i < limit; i++) begin
      if (pickIn ? trigRecv : trigOut) begin
        count++;
        if (firstPh < 0) firstPh = phase;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    int fp, cnt, r;
    string tag;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 trigOut in reset", trigOut, 0);
    check("R1 trigRecv in reset", trigRecv, 0);
    check("R1 syncClk in reset", syncClk, 1);
    rstN = 1'b1;

    // Vector table walk (R3, R4, R5, R6)
    foreach (VECS[k]) begin
      divRatio = VECS[k].ratio;
      bypassEn = VECS[k].byp;
      r = int'(VECS[k].ratio);
      restart();
      repeat (int'(VECS[k].off)) @(negedge clk);
      if (!VECS[k].dirIn) begin
        tag = VECS[k].byp ? "R5" : "R3";
        sendReq = 1'b1;
        @(negedge clk) sendReq = 1'b0;
        findPulse(1'b0, 3 * r + 8, fp, cnt);
        check({tag, " trigOut phase"}, fp, expOut(r, VECS[k].byp, int'(VECS[k].off)));
        check({tag, " trigOut pulse count"}, cnt, 1);
      end else begin
        tag = VECS[k].byp ? "R6" : "R4";
        trigIn = 1'b1;
        @(negedge clk);
        findPulse(1'b1, 3 * r + 8, fp, cnt);
        check({tag, " trigRecv phase"}, fp, expIn(r, VECS[k].byp, int'(VECS[k].off)));
        check({tag, " trigRecv pulse count"}, cnt, 1);
        trigIn = 1'b0;
      end
      repeat (4) @(negedge clk);
    end

    // R2 sync clock shape, ratio 6
    bypassEn = 1'b0;
    divRatio = 8'd6;
    restart();
    for (int p = 0; p < 12; p++) begin
      check("R2 syncClk shape", syncClk, ((p % 6) < 3) ? 1 : 0);
      @(negedge clk);
    end

    // R8 restart from the middle of a period
    repeat (4) @(negedge clk);
    restart();
    for (int p = 0; p < 6; p++) begin
      check("R8 syncClk after mid-phase restart", syncClk, (p < 3) ? 1 : 0);
      @(negedge clk);
    end

    // R9 odd ratio 5 acts as 4
    divRatio = 8'd5;
    restart();
    for (int p = 0; p < 8; p++) begin
      check("R9 odd ratio rounds down", syncClk, ((p % 4) < 2) ? 1 : 0);
      @(negedge clk);
    end
    // R9 ratio 0 acts as 2
    divRatio = 8'd0;
    restart();
    for (int p = 0; p < 6; p++) begin
      check("R9 tiny ratio acts as two", syncClk, ((p % 2) < 1) ? 1 : 0);
      @(negedge clk);
    end

    // R7 two requests before release merge into one pulse
    divRatio = 8'd8;
    restart();
    @(negedge clk) sendReq = 1'b1;
    @(negedge clk) sendReq = 1'b0;
    @(negedge clk) sendReq = 1'b1;
    @(negedge clk) sendReq = 1'b0;
    findPulse(1'b0, 24, fp, cnt);
    check("R7 merged trigOut phase", fp, 9);
    check("R7 merged trigOut count", cnt, 1);

    // R10 held input gives one event
    divRatio = 8'd4;
    restart();
    trigIn = 1'b1;
    @(negedge clk);
    findPulse(1'b1, 30, fp, cnt);
    check("R10 held trigIn pulse count", cnt, 1);
    trigIn = 1'b0;
    bypassEn = 1'b1;
    repeat (4) @(negedge clk);
    trigIn = 1'b1;
    @(negedge clk);
    findPulse(1'b1, 20, fp, cnt);
    check("R10 held trigIn bypass pulse count", cnt, 1);
    trigIn = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule